// File: doc/BRIEF.md
# Hash Offload Command and Status Register Block

This block is the software-facing control front of a hash offload engine. A host reaches it over a simple 32-bit register bus, with one write strobe, a byte address and combinational read data. Through that bus the host programs the source pointer, the destination pointer, the key buffer pointer and the source byte count. Each of these values is trimmed by a per-register mask when it is written. The block drives the pointers and the count straight to a separate hashing datapath, which is not part of this block.

A write to the hash command word is decoded at once. The three-bit primary algorithm field picks a digest family. When the primary field selects the wide (512-bit state) family, a second three-bit field picks the variant inside it. If the pair is legal, the block issues a single-cycle start pulse. The pulse carries a three-bit algorithm code, the scatter-gather flag and the accumulative-mode flag. An illegal pair starts nothing, but the masked command word is still stored. Keyed-hash mode and chained cipher mode cannot be served here, so a command asking for either only raises a one-cycle "unsupported" flag.

When the datapath reports completion, a done bit is set in the status word whatever the interrupt enable holds. The interrupt line rises only when the stored command has its enable bit set. Software writes a one to the done bit to clear the done bit and the interrupt together.

Top module: `hsh_cmd_regs`

## Requirements
- R1: After reset, every register reads zero, and `irq_o`, `start_o` and both unsupported flags are low.
- R2: Each write is masked and read back masked. Source pointer (0x20) keeps bits [30:0]. Destination (0x24) and key pointer (0x28) keep bits [30:3], so the destination is always 8-byte aligned. Source count (0x2C) keeps bits [27:0]. Command (0x30) is ANDed with 0x00147FFF. The pointer and count outputs show the stored values.
- R3: The primary field is command bits [6:4], and the variant field is bits [12:10], which must be 0 here. Primary 3'b000 gives start code 0 (MD5), 3'b010 gives code 1 (SHA-1), 3'b100 gives code 2 (SHA-224) and 3'b101 gives code 3 (SHA-256).
- R4: Primary 3'b110 selects the wide family. Variant 3'b000 gives code 4 (SHA-512), 3'b001 gives code 5 (SHA-384), 3'b010 gives code 6 (SHA-512/256) and 3'b011 gives code 7 (SHA-512/224).
- R5: Any other combination of the two fields gives no start pulse, and the command register still holds the masked written value.
- R6: `start_o` is high for exactly the one cycle after the accepted command write. `start_sg_o` equals command bit 18. `start_accum_o` is 1 only when mode bits [8:7] equal 2'b10.
- R7: A `done_i` pulse sets status bit 9 (offset 0x1C) whether or not the interrupt is enabled. `irq_o` rises only if command bit 9 is 1 at that time.
- R8: A status write with bit 9 set clears status bit 9 and `irq_o`. A status write with bit 9 clear changes neither.
- R9: Byte addresses at or above 0x34 read zero, and writes to them change no register. Offsets inside the span that have no register also read zero.
- R10: A command write with bit 7 set pulses `hmac_unsup_o` for one cycle. A command write with bit 1 set pulses `casc_unsup_o` for one cycle. Neither flag blocks a valid start.
- R11: The cipher command word (0x10) is stored in full and read back, and writing it never starts a hash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW (12) | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| done_i | input | 1 | Completion pulse from the datapath |
| start_o | output | 1 | One-cycle start strobe |
| start_algo_o | output | 3 | Decoded algorithm code |
| start_sg_o | output | 1 | Scatter-gather request for this start |
| start_accum_o | output | 1 | Accumulative mode for this start |
| hmac_unsup_o | output | 1 | Keyed mode was requested (unsupported) |
| casc_unsup_o | output | 1 | Chained cipher mode was requested (unsupported) |
| src_addr_o | output | 32 | Stored source pointer |
| dst_addr_o | output | 32 | Stored destination pointer |
| key_addr_o | output | 32 | Stored key buffer pointer |
| src_len_o | output | 32 | Stored source byte count |
| irq_o | output | 1 | Completion interrupt |

## Verification
Commands are written for every legal primary code and every legal wide-family variant, so that each algorithm code is shown to be reached by exactly one encoding. Near misses follow: a lone bit 4, the fully set primary field, a variant on a non-wide family, and a bit 12 variant. These separate "decodes the primary field only" from a true two-level check. Mode and flag patterns (accumulative, keyed key, chained, scatter-gather) show that each flag follows its own bit. Completions with the enable off and then on, followed by status writes of zero and of bit 9, show that the done bit and the interrupt line are held and cleared apart from each other.

// File: rtl/hsh_pkg.sv
package hsh_pkg;

    // byte offsets the host software depends on
    localparam int unsigned OFS_CRYPT = 'h10;
    localparam int unsigned OFS_STS   = 'h1C;
    localparam int unsigned OFS_SRC   = 'h20;
    localparam int unsigned OFS_DST   = 'h24;
    localparam int unsigned OFS_KEY   = 'h28;
    localparam int unsigned OFS_LEN   = 'h2C;
    localparam int unsigned OFS_CMD   = 'h30;

    // command word bit positions
    localparam int unsigned CMD_CASC_BIT = 1;
    localparam int unsigned CMD_PRI_LSB  = 4;
    localparam int unsigned CMD_MODE_LSB = 7;
    localparam int unsigned CMD_IEN_BIT  = 9;
    localparam int unsigned CMD_SUB_LSB  = 10;
    localparam int unsigned CMD_SG_BIT   = 18;

    // status word bit position
    localparam int unsigned STS_DONE_BIT = 9;

    typedef enum logic [2:0] {
        ALG_MD5        = 3'd0,
        ALG_SHA1       = 3'd1,
        ALG_SHA224     = 3'd2,
        ALG_SHA256     = 3'd3,
        ALG_SHA512     = 3'd4,
        ALG_SHA384     = 3'd5,
        ALG_SHA512_256 = 3'd6,
        ALG_SHA512_224 = 3'd7
    } hsh_algo_e;

    typedef enum logic [1:0] {
        MODE_DIGEST   = 2'b00,
        MODE_HMAC     = 2'b01,
        MODE_ACCUM    = 2'b10,
        MODE_HMAC_KEY = 2'b11
    } hsh_mode_e;

    typedef struct packed {
        hsh_algo_e algo;
        logic      sg;
        logic      accum;
    } hsh_job_t;

endpackage

// File: rtl/hsh_algo_dec.sv
module hsh_algo_dec
    import hsh_pkg::*;
(
    input  logic     [2:0] pri_i,
    input  logic     [2:0] sub_i,
    input  logic     [1:0] mode_i,
    input  logic           sg_i,
    input  logic           casc_i,
    output logic           ok_o,
    output hsh_job_t       job_o,
    output logic           hmac_o,
    output logic           casc_o
);

    logic      ok;
    hsh_algo_e algo;

    // two-level decode: the variant field is only meaningful for the wide family
    always_comb begin
        ok   = 1'b1;
        algo = ALG_MD5;
        unique case (pri_i)
            3'b000: begin algo = ALG_MD5;    ok = (sub_i == 3'b000); end
            3'b010: begin algo = ALG_SHA1;   ok = (sub_i == 3'b000); end
            3'b100: begin algo = ALG_SHA224; ok = (sub_i == 3'b000); end
            3'b101: begin algo = ALG_SHA256; ok = (sub_i == 3'b000); end
            3'b110: begin
                unique case (sub_i)
                    3'b000:  algo = ALG_SHA512;
                    3'b001:  algo = ALG_SHA384;
                    3'b010:  algo = ALG_SHA512_256;
                    3'b011:  algo = ALG_SHA512_224;
                    default: ok   = 1'b0;
                endcase
            end
            default: ok = 1'b0;
        endcase
    end

    assign ok_o        = ok;
    assign job_o.algo  = algo;
    assign job_o.sg    = sg_i;
    assign job_o.accum = (hsh_mode_e'(mode_i) == MODE_ACCUM);
    assign hmac_o      = mode_i[0];
    assign casc_o      = casc_i;

endmodule

// File: rtl/hsh_done_irq.sv
module hsh_done_irq (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic done_i,
    input  logic ien_i,
    input  logic clr_i,
    output logic sts_o,
    output logic irq_o
);

    typedef struct packed {
        logic sts;
        logic irq;
    } st_t;

    st_t st_d, st_q;

    // completion wins over a clear landing in the same cycle
    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.sts = 1'b0;
            st_d.irq = 1'b0;
        end
        if (done_i) begin
            st_d.sts = 1'b1;
            if (ien_i) begin
                st_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_o = st_q.sts;
    assign irq_o = st_q.irq;

    AST_DONE_SETS_STS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> sts_o); // R7
    AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !ien_i && !irq_o) |=> !irq_o); // R7
    AST_IRQ_WITH_STS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> sts_o); // R7
    AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !done_i) |=> (!sts_o && !irq_o)); // R8

endmodule

// File: rtl/hsh_cmd_regs.sv
module hsh_cmd_regs
    import hsh_pkg::*;
#(
    parameter int unsigned AW        = 12,
    parameter int unsigned NUM_WORDS = 13,
    parameter logic [31:0] SRC_MASK  = 32'h7FFF_FFFF,
    parameter logic [31:0] DST_MASK  = 32'h7FFF_FFF8,
    parameter logic [31:0] KEY_MASK  = 32'h7FFF_FFF8,
    parameter logic [31:0] LEN_MASK  = 32'h0FFF_FFFF,
    parameter logic [31:0] CMD_MASK  = 32'h0014_7FFF
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [31:0]   wdata_i,
    output logic [31:0]   rdata_o,
    input  logic          done_i,
    output logic          start_o,
    output logic [2:0]    start_algo_o,
    output logic          start_sg_o,
    output logic          start_accum_o,
    output logic          hmac_unsup_o,
    output logic          casc_unsup_o,
    output logic [31:0]   src_addr_o,
    output logic [31:0]   dst_addr_o,
    output logic [31:0]   key_addr_o,
    output logic [31:0]   src_len_o,
    output logic          irq_o
);

    localparam int unsigned WW       = AW - 2;
    localparam logic [AW:0] SPAN     = (AW + 1)'(NUM_WORDS * 4);
    localparam logic [WW-1:0] W_CRYPT = WW'(OFS_CRYPT / 4);
    localparam logic [WW-1:0] W_STS   = WW'(OFS_STS / 4);
    localparam logic [WW-1:0] W_SRC   = WW'(OFS_SRC / 4);
    localparam logic [WW-1:0] W_DST   = WW'(OFS_DST / 4);
    localparam logic [WW-1:0] W_KEY   = WW'(OFS_KEY / 4);
    localparam logic [WW-1:0] W_LEN   = WW'(OFS_LEN / 4);
    localparam logic [WW-1:0] W_CMD   = WW'(OFS_CMD / 4);

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] key;
        logic [31:0] len;
        logic [31:0] cmd;
        logic [31:0] crypt;
        hsh_job_t    job;
        logic        start;
        logic        hmac;
        logic        casc;
    } regs_t;

    regs_t r_d, r_q;

    logic          in_range;
    logic          wr_hit;
    logic [WW-1:0] word;
    logic          cmd_wr;
    logic          sts_clr;
    logic          sts_done;

    logic          dec_ok;
    hsh_job_t      dec_job;
    logic          dec_hmac;
    logic          dec_casc;

    assign in_range = ({1'b0, addr_i} < SPAN);
    assign word     = addr_i[AW-1:2];
    assign wr_hit   = wr_en_i && in_range;
    assign cmd_wr   = wr_hit && (word == W_CMD);
    assign sts_clr  = wr_hit && (word == W_STS) && wdata_i[STS_DONE_BIT];

    // decode the masked value being written, so start follows the write by one edge
    hsh_algo_dec u_dec (
        .pri_i  (wdata_i[CMD_PRI_LSB +: 3]  & CMD_MASK[CMD_PRI_LSB +: 3]),
        .sub_i  (wdata_i[CMD_SUB_LSB +: 3]  & CMD_MASK[CMD_SUB_LSB +: 3]),
        .mode_i (wdata_i[CMD_MODE_LSB +: 2] & CMD_MASK[CMD_MODE_LSB +: 2]),
        .sg_i   (wdata_i[CMD_SG_BIT]   & CMD_MASK[CMD_SG_BIT]),
        .casc_i (wdata_i[CMD_CASC_BIT] & CMD_MASK[CMD_CASC_BIT]),
        .ok_o   (dec_ok),
        .job_o  (dec_job),
        .hmac_o (dec_hmac),
        .casc_o (dec_casc)
    );

    hsh_done_irq u_sts (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .done_i (done_i),
        .ien_i  (r_q.cmd[CMD_IEN_BIT]),
        .clr_i  (sts_clr),
        .sts_o  (sts_done),
        .irq_o  (irq_o)
    );

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.hmac  = 1'b0;
        r_d.casc  = 1'b0;
        if (wr_hit) begin
            unique case (word)
                W_CRYPT: r_d.crypt = wdata_i;
                W_SRC:   r_d.src   = wdata_i & SRC_MASK;
                W_DST:   r_d.dst   = wdata_i & DST_MASK;
                W_KEY:   r_d.key   = wdata_i & KEY_MASK;
                W_LEN:   r_d.len   = wdata_i & LEN_MASK;
                W_CMD: begin
                    r_d.cmd  = wdata_i & CMD_MASK;
                    r_d.hmac = dec_hmac;
                    r_d.casc = dec_casc;
                    if (dec_ok) begin
                        r_d.start = 1'b1;
                        r_d.job   = dec_job;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (in_range) begin
            unique case (word)
                W_CRYPT: rdata_o = r_q.crypt;
                W_STS:   rdata_o = 32'(sts_done) << STS_DONE_BIT;
                W_SRC:   rdata_o = r_q.src;
                W_DST:   rdata_o = r_q.dst;
                W_KEY:   rdata_o = r_q.key;
                W_LEN:   rdata_o = r_q.len;
                W_CMD:   rdata_o = r_q.cmd;
                default: rdata_o = '0;
            endcase
        end
    end

    assign start_o       = r_q.start;
    assign start_algo_o  = r_q.job.algo;
    assign start_sg_o    = r_q.job.sg;
    assign start_accum_o = r_q.job.accum;
    assign hmac_unsup_o  = r_q.hmac;
    assign casc_unsup_o  = r_q.casc;
    assign src_addr_o    = r_q.src;
    assign dst_addr_o    = r_q.dst;
    assign key_addr_o    = r_q.key;
    assign src_len_o     = r_q.len;

    AST_START_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |-> $past(cmd_wr && dec_ok)); // R3
    AST_REJECT_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_wr && !dec_ok) |=> !start_o); // R5
    AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_o && !cmd_wr) |=> !start_o); // R6
    AST_OOR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !in_range) |=> ($stable(src_addr_o) && $stable(dst_addr_o) &&
                                    $stable(key_addr_o) && $stable(src_len_o))); // R9

endmodule

// File: tb/hsh_cmd_regs_tb.sv
`timescale 1ns/1ps
module hsh_cmd_regs_tb;

    localparam int unsigned AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          done = 1'b0;
    logic          start;
    logic [2:0]    algo;
    logic          sg, accum, hmac_f, casc_f, irq;
    logic [31:0]   src_a, dst_a, key_a, len_v;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    hsh_cmd_regs u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .done_i(done), .start_o(start),
        .start_algo_o(algo), .start_sg_o(sg), .start_accum_o(accum),
        .hmac_unsup_o(hmac_f), .casc_unsup_o(casc_f), .src_addr_o(src_a),
        .dst_addr_o(dst_a), .key_addr_o(key_a), .src_len_o(len_v), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // returns on the falling edge after the write edge
    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic cmd_chk(input string req, input logic [31:0] d, input bit exp_go,
                           input logic [2:0] exp_algo, input bit exp_sg, input bit exp_acc,
                           input bit exp_hmac, input bit exp_casc);
        bus_wr(12'h030, d);
        chk({req, " start"}, 32'(start), 32'(exp_go));
        if (exp_go) begin
            chk({req, " algo"}, 32'(algo), 32'(exp_algo));
            chk({req, " sg"}, 32'(sg), 32'(exp_sg));
            chk({req, " accum"}, 32'(accum), 32'(exp_acc));
        end
        chk({req, " hmac flag"}, 32'(hmac_f), 32'(exp_hmac));
        chk({req, " casc flag"}, 32'(casc_f), 32'(exp_casc));
        @(negedge clk);
        chk({req, " pulse end"}, {29'd0, start, hmac_f, casc_f}, 32'd0);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq", 32'(irq), 0);
        chk("R1 start", {29'd0, start, hmac_f, casc_f}, 0);
        for (int a = 'h10; a <= 'h30; a += 4) rd_chk("R1 reg", AW'(a), 0);
    endtask

    task automatic t_masks();
        bus_wr(12'h020, 32'hFFFF_FFFF);
        bus_wr(12'h024, 32'hFFFF_FFFF);
        bus_wr(12'h028, 32'hFFFF_FFFF);
        bus_wr(12'h02C, 32'hFFFF_FFFF);
        rd_chk("R2 src", 12'h020, 32'h7FFF_FFFF);
        rd_chk("R2 dst", 12'h024, 32'h7FFF_FFF8);
        rd_chk("R2 key", 12'h028, 32'h7FFF_FFF8);
        rd_chk("R2 len", 12'h02C, 32'h0FFF_FFFF);
        chk("R2 dst port", dst_a, 32'h7FFF_FFF8);
        chk("R2 len port", len_v, 32'h0FFF_FFFF);
        bus_wr(12'h024, 32'h1234_5677);
        chk("R2 dst align", dst_a, 32'h1234_5670);
        chk("R2 src port", src_a, 32'h7FFF_FFFF);
        chk("R2 key port", key_a, 32'h7FFF_FFF8);
        // all-ones primary field is illegal: no start, masked store
        cmd_chk("R2 cmd ones", 32'hFFFF_FFFF, 0, 0, 0, 0, 1, 1);
        rd_chk("R2 cmd mask", 12'h030, 32'h0014_7FFF);
    endtask

    task automatic t_primary();
        cmd_chk("R3 md5",    32'h0000_0000, 1, 3'd0, 0, 0, 0, 0);
        cmd_chk("R3 sha1",   32'h0000_0020, 1, 3'd1, 0, 0, 0, 0);
        cmd_chk("R3 sha224", 32'h0000_0040, 1, 3'd2, 0, 0, 0, 0);
        cmd_chk("R3 sha256", 32'h0000_0050, 1, 3'd3, 0, 0, 0, 0);
    endtask

    task automatic t_wide();
        cmd_chk("R4 sha512",     32'h0000_0060, 1, 3'd4, 0, 0, 0, 0);
        cmd_chk("R4 sha384",     32'h0000_0460, 1, 3'd5, 0, 0, 0, 0);
        cmd_chk("R4 sha512_256", 32'h0000_0860, 1, 3'd6, 0, 0, 0, 0);
        cmd_chk("R4 sha512_224", 32'h0000_0C60, 1, 3'd7, 0, 0, 0, 0);
    endtask

    task automatic t_reject();
        cmd_chk("R5 bit4 only",   32'h0000_0010, 0, 0, 0, 0, 0, 0);
        cmd_chk("R5 pri 011",     32'h0000_0030, 0, 0, 0, 0, 0, 0);
        cmd_chk("R5 sha1 variant", 32'h0000_0420, 0, 0, 0, 0, 0, 0);
        cmd_chk("R5 wide bit12",  32'h0000_1060, 0, 0, 0, 0, 0, 0);
        rd_chk("R5 stored", 12'h030, 32'h0000_1060);
    endtask

    task automatic t_flags();
        cmd_chk("R6 sg",        32'h0004_0050, 1, 3'd3, 1, 0, 0, 0);
        cmd_chk("R6 accum",     32'h0000_0150, 1, 3'd3, 0, 1, 0, 0);
        cmd_chk("R6 hmac key",  32'h0000_01A0, 1, 3'd1, 0, 0, 1, 0);
        cmd_chk("R6 sg accum wide", 32'h0004_0560, 1, 3'd5, 1, 1, 0, 0);
    endtask

    task automatic t_unsup();
        cmd_chk("R10 hmac",   32'h0000_00C0, 1, 3'd2, 0, 0, 1, 0);
        cmd_chk("R10 casc",   32'h0000_0052, 1, 3'd3, 0, 0, 0, 1);
        cmd_chk("R10 both bad algo", 32'h0000_0092, 0, 0, 0, 0, 1, 1);
    endtask

    task automatic t_done_irq();
        cmd_chk("R7 setup noien", 32'h0000_0050, 1, 3'd3, 0, 0, 0, 0);
        pulse_done();
        rd_chk("R7 sts noien", 12'h01C, 32'h0000_0200);
        chk("R7 irq noien", 32'(irq), 0);
        bus_wr(12'h01C, 32'h0000_0200);
        rd_chk("R8 sts cleared", 12'h01C, 0);
        cmd_chk("R7 setup ien", 32'h0000_0250, 1, 3'd3, 0, 0, 0, 0);
        pulse_done();
        chk("R7 irq ien", 32'(irq), 1);
        rd_chk("R7 sts ien", 12'h01C, 32'h0000_0200);
    endtask

    task automatic t_w1c();
        bus_wr(12'h01C, 32'hFFFF_FDFF);
        chk("R8 zero write irq", 32'(irq), 1);
        rd_chk("R8 zero write sts", 12'h01C, 32'h0000_0200);
        bus_wr(12'h01C, 32'h0000_0200);
        chk("R8 w1c irq", 32'(irq), 0);
        rd_chk("R8 w1c sts", 12'h01C, 0);
    endtask

    task automatic t_oor();
        bus_wr(12'h020, 32'h0000_1000);
        bus_wr(12'h034, 32'hAAAA_AAAA);
        bus_wr(12'hFFC, 32'h5555_5555);
        bus_wr(12'h834, 32'hFFFF_FFFF);
        rd_chk("R9 read 0x34", 12'h034, 0);
        rd_chk("R9 read 0xFFC", 12'hFFC, 0);
        rd_chk("R9 hole 0x14", 12'h014, 0);
        rd_chk("R9 src kept", 12'h020, 32'h0000_1000);
        chk("R9 src port kept", src_a, 32'h0000_1000);
        chk("R9 no start", 32'(start), 0);
    endtask

    task automatic t_crypt();
        bus_wr(12'h010, 32'hDEAD_BEEF);
        chk("R11 no start", 32'(start), 0);
        rd_chk("R11 readback", 12'h010, 32'hDEAD_BEEF);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_primary();
        t_wide();
        t_reject();
        t_flags();
        t_unsup();
        t_done_irq();
        t_w1c();
        t_oor();
        t_crypt();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule